// File: doc/BRIEF.md
# SONET frame-aligning 1:32 deserializer

This block turns a serial bit stream, one bit per clock, into 32-bit parallel words. The clock of the block is the bit clock. A one-cycle word-valid strobe marks each finished word, and the word, the sync flag and the parity bit are registered on that strobe and held until the next one. The first bit of a word lands in bit 31 and the last in bit 0.

While the hold input is low, a marker search runs on the incoming bits. It looks for the last A1 framing byte (0xF6) followed at once by the first A2 byte (0x28). When that 16-bit marker ends on a bit, the word phase restarts, so the next bit opens a new word and the A2 bytes sit byte-aligned in the output. The word being built when the phase restarts is thrown away, which takes out one strobe. When the third aligned word reaches the output, a one-word sync pulse rides with it. A framer drops hold to low, waits for the sync pulse, then raises hold so the found alignment stays fixed.

A parity bit rides with each word and covers the data and the sync flag. A select input picks odd or even parity. The reset request acts only after it has been sampled high on 16 bit clocks in a row. Reset puts the phase back to its reset state and clears the outputs. With hold high, the block is then a plain 1:32 demultiplexer.

Top module: `sonet_deser_frame`

## Requirements
- R1: Each word holds 32 consecutive received bits: the earliest bit is in word bit 31 and the latest in bit 0. The word shows up, with word_vld high for one cycle, in the cycle right after its last bit is sampled.
- R2: With no realignment, word_vld pulses once every 32 clocks. It is never high on two cycles in a row. The first word after reset is made of the first 32 bits sampled after the reset request goes low.
- R3: Suppose hold is low when a bit is sampled that completes 0xF6 then 0x28, MSB first, over the last 16 bits. Then the next bit sampled becomes bit 31 of a new word.
- R4: If that realignment bit does not end a word, the partial word is discarded, so one strobe is missing and the gap between strobes is between 33 and 63 clocks. If it does end a word, that word is emitted and no strobe is lost.
- R5: sync_out is 1 exactly with the third word after a realignment (0x28282828 in a framed stream) and 0 with every other word. It changes only when a new word is presented.
- R6: While hold is high, no realignment takes place and no new sync pulse starts. The word phase and the strobe spacing carry on unchanged.
- R7: parity_out is chosen so that the count of ones over word_out, sync_out and parity_out is odd when even_par_sel was 0 and even when it was 1. even_par_sel is sampled at the clock that ends the word.
- R8: A reset request held high for fewer than 16 consecutive clocks has no effect: words keep their content and their phase.
- R9: A reset request held for 16 or more clocks clears word_out, word_vld, sync_out and parity_out to 0, and it removes any alignment found before.

Top module ports, in port-list order:

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock; one serial bit is sampled per rising edge |
| rst_req | input | 1 | Reset request, active high, has an effect only after 16 consecutive high samples |
| ser_in | input | 1 | Serial data bit |
| frame_hold | input | 1 | 1 freezes the current word phase; 0 allows the marker search to realign |
| even_par_sel | input | 1 | 0 selects odd parity, 1 selects even parity |
| word_out | output | 32 | Assembled word, first received bit in bit 31 |
| word_vld | output | 1 | One-cycle strobe when a new word is presented |
| sync_out | output | 1 | High with the third word after a realignment |
| parity_out | output | 1 | Parity bit over word_out and sync_out |

## Verification
Two events can fall in the same clock: the marker match that restarts the word phase, and the word strobe of the old phase. The bench puts one frame after a prefix of each length from 0 to 31 bits, so the match lands on every word phase once. With a 24-bit prefix the match falls on the very bit that ends an old word. There the expected strobe count has no gap and the sync word keeps its place. For every other prefix the count must be one short and the words after the match must start on the bit that follows it.

// File: rtl/sdes_pkg.sv
package sdes_pkg;

  // Framing marker bytes: the last A1 byte is followed directly by the first A2 byte.
  localparam logic [7:0] SDES_A1 = 8'hF6;
  localparam logic [7:0] SDES_A2 = 8'h28;

  // Parity fill bit: ones_odd is the XOR of the covered bits.
  // even_sel = 1 makes the total even, 0 makes it odd.
  function automatic logic fill_bit(input logic ones_odd, input logic even_sel);
    return ones_odd ^ ~even_sel;
  endfunction

endpackage

// File: rtl/sdes_rst_filter.sv
module sdes_rst_filter #(
  parameter int RST_HOLD = 16
) (
  input  logic clk,
  input  logic rst_req,
  output logic clr
);

  // History of the last RST_HOLD samples; clear only when all of them are high.
  logic [RST_HOLD-1:0] hist;

  always_ff @(posedge clk) begin
    hist <= {hist[RST_HOLD-2:0], rst_req};
  end

  assign clr = &hist;

endmodule

// File: rtl/sdes_frame_detect.sv
module sdes_frame_detect #(
  parameter logic [7:0] MARK_A1 = 8'hF6,
  parameter logic [7:0] MARK_A2 = 8'h28
) (
  input  logic clk,
  input  logic clr,
  input  logic din,
  input  logic frame_hold,
  output logic realign
);

  localparam int MW = 16;

  logic [MW-2:0] hist;
  logic          hit;

  always_ff @(posedge clk) begin
    if (clr) hist <= '0;
    else     hist <= {hist[MW-3:0], din};
  end

  // The match includes the bit being sampled now, so the phase restarts on this same edge.
  assign hit     = ({hist, din} == {MARK_A1, MARK_A2});
  assign realign = hit && !frame_hold;

endmodule

// File: rtl/sdes_word_pack.sv
module sdes_word_pack #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              clr,
  input  logic              din,
  input  logic              realign,
  output logic              strobe,
  output logic [WORD_W-1:0] word_nxt
);

  localparam int CW = $clog2(WORD_W);

  logic [CW-1:0]     cnt;
  logic [WORD_W-2:0] sr;

  always_ff @(posedge clk) begin
    if (clr) begin
      cnt <= '0;
      sr  <= '0;
    end else begin
      sr <= {sr[WORD_W-3:0], din};
      if (strobe || realign) cnt <= '0;
      else                   cnt <= cnt + 1'b1;
    end
  end

  assign strobe   = (cnt == CW'(WORD_W - 1));
  assign word_nxt = {sr, din};

endmodule

// File: rtl/sonet_deser_frame.sv
module sonet_deser_frame import sdes_pkg::*; #(
  parameter int         WORD_W    = 32,
  parameter int         RST_HOLD  = 16,
  parameter int         SYNC_WORD = 3,
  parameter logic [7:0] MARK_A1   = SDES_A1,
  parameter logic [7:0] MARK_A2   = SDES_A2
) (
  input  logic              clk,
  input  logic              rst_req,
  input  logic              ser_in,
  input  logic              frame_hold,
  input  logic              even_par_sel,
  output logic [WORD_W-1:0] word_out,
  output logic              word_vld,
  output logic              sync_out,
  output logic              parity_out
);

  localparam int SW = $clog2(SYNC_WORD + 1);
  localparam int GW = $clog2(2 * WORD_W) + 1;
  localparam int IW = $clog2(3 * WORD_W + 2) + 1;

  logic              clr;
  logic              realign;
  logic              strobe;
  logic              sync_fire;
  logic [WORD_W-1:0] word_nxt;
  logic [SW-1:0]     sync_left;

  sdes_rst_filter #(.RST_HOLD(RST_HOLD)) u_rst (
    .clk     (clk),
    .rst_req (rst_req),
    .clr     (clr)
  );

  sdes_frame_detect #(.MARK_A1(MARK_A1), .MARK_A2(MARK_A2)) u_det (
    .clk        (clk),
    .clr        (clr),
    .din        (ser_in),
    .frame_hold (frame_hold),
    .realign    (realign)
  );

  sdes_word_pack #(.WORD_W(WORD_W)) u_pack (
    .clk      (clk),
    .clr      (clr),
    .din      (ser_in),
    .realign  (realign),
    .strobe   (strobe),
    .word_nxt (word_nxt)
  );

  assign sync_fire = strobe && (sync_left == SW'(1));

  always_ff @(posedge clk) begin
    if (clr) begin
      word_out   <= '0;
      word_vld   <= 1'b0;
      sync_out   <= 1'b0;
      parity_out <= 1'b0;
      sync_left  <= '0;
    end else begin
      word_vld <= strobe;
      if (strobe) begin
        word_out   <= word_nxt;
        sync_out   <= sync_fire;
        parity_out <= fill_bit(^{word_nxt, sync_fire}, even_par_sel);
      end
      if (realign)                           sync_left <= SW'(SYNC_WORD);
      else if (strobe && sync_left != '0)    sync_left <= sync_left - 1'b1;
    end
  end

  // Checker state: cycles since the last strobe, and how long hold has been high.
  logic [GW-1:0] gap_cnt;
  logic          seen_vld;
  logic [IW-1:0] hold_run;

  always_ff @(posedge clk) begin
    if (clr) begin
      gap_cnt  <= '0;
      seen_vld <= 1'b0;
      hold_run <= '0;
    end else begin
      if (word_vld)                          gap_cnt <= '0;
      else if (gap_cnt != GW'(2 * WORD_W))   gap_cnt <= gap_cnt + 1'b1;
      seen_vld <= seen_vld | word_vld;
      if (!frame_hold)                           hold_run <= '0;
      else if (hold_run != IW'(3 * WORD_W + 1))  hold_run <= hold_run + 1'b1;
    end
  end

  AST_VLD_PULSE: assert property (@(posedge clk) disable iff (rst_req || clr)
    word_vld |=> !word_vld); // R2

  AST_WORD_HELD: assert property (@(posedge clk) disable iff (rst_req || clr)
    (!word_vld && !$past(clr)) |-> $stable(word_out)); // R1

  AST_SYNC_ON_WORD: assert property (@(posedge clk) disable iff (rst_req || clr)
    $rose(sync_out) |-> word_vld); // R5

  AST_PARITY_FILL: assert property (@(posedge clk) disable iff (rst_req || clr)
    word_vld |-> ((^{word_out, sync_out, parity_out}) == !$past(even_par_sel))); // R7

  AST_GAP_RANGE: assert property (@(posedge clk) disable iff (rst_req || clr)
    (word_vld && seen_vld) |-> (gap_cnt >= GW'(WORD_W - 1) && gap_cnt <= GW'(2 * WORD_W - 2))); // R4

  AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (rst_req || clr)
    $rose(sync_out) |-> (hold_run <= IW'(3 * WORD_W))); // R6

endmodule

// File: tb/tb_sonet_deser_frame.sv
`timescale 1ns/1ps
module tb_sonet_deser_frame;

  localparam int W       = 32;
  localparam int NB      = 2560;
  localparam int RST_CYC = 20;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_req = 1'b1, ser_in = 1'b0, frame_hold = 1'b1, even_par_sel = 1'b0;
  logic [W-1:0] word_out;
  logic word_vld, sync_out, parity_out;

  sonet_deser_frame dut (
    .clk (clk), .rst_req (rst_req), .ser_in (ser_in), .frame_hold (frame_hold),
    .even_par_sel (even_par_sel), .word_out (word_out), .word_vld (word_vld),
    .sync_out (sync_out), .parity_out (parity_out)
  );

  int   total = 0, bad = 0;
  bit   done = 0;
  logic bits [NB];
  int   nbits = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic push_bit(input logic b);
    bits[nbits] = b;
    nbits++;
  endtask

  task automatic push_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) push_bit(v[i]);
  endtask

  // Payload bytes have bits 7 and 3 cleared: never four ones in a row, so no false marker.
  task automatic push_payload(input int nbytes);
    for (int i = 0; i < nbytes; i++) push_byte(8'($urandom) & 8'h77);
  endtask

  task automatic push_prefix(input int n);
    for (int i = 0; i < n; i++) push_bit((i % 4 == 0) ? 1'b0 : 1'($urandom));
  endtask

  task automatic push_frame();
    for (int i = 0; i < 48; i++) push_byte(8'hF6);
    for (int i = 0; i < 48; i++) push_byte(8'h28);
  endtask

  function automatic logic [W-1:0] slice(input int start);
    logic [W-1:0] w = '0;
    for (int i = 0; i < W; i++)
      if (start + i >= 0 && start + i < NB) w[W-1-i] = bits[start + i];
    return w;
  endfunction

  task automatic do_reset(input logic hold_v);
    @(negedge clk);
    rst_req = 1'b1; ser_in = 1'b0; frame_hold = hold_v;
    repeat (RST_CYC) @(negedge clk);
    chk(word_out == '0, "R9", word_out, 32'd0);
    chk(word_vld == 1'b0, "R9", 32'(word_vld), 32'd0);
    chk(sync_out == 1'b0, "R9", 32'(sync_out), 32'd0);
    chk(parity_out == 1'b0, "R9", 32'(parity_out), 32'd0);
    rst_req = 1'b0;
    nbits = 0;
  endtask

  // m: index of the bit that completes the marker; srst: start of a 15-cycle reset pulse (-1 none).
  task automatic run_stream(input bit framed, input int m, input int srst);
    int pos = 0, words = 0, syncs = 0, start, exp_n, exp_start;
    bit ph_ok, exp_sync;
    string tg;
    for (int it = 0; it <= nbits; it++) begin
      @(negedge clk);
      if (word_vld) begin
        start = pos - W;
        words++;
        if (sync_out) syncs++;
        tg = (framed && start > m) ? "R3" : "R1";
        if (srst >= 0 && start + W > srst) tg = "R8";
        chk(start >= 0 && word_out == slice(start), tg, word_out, slice(start));
        if (framed && start > m) begin
          ph_ok = ((start - m - 1) % W == 0);
          exp_start = m + 1 + W * ((start - m - 1) / W);
        end else begin
          ph_ok = (start % W == 0) && (!framed || start + W - 1 <= m);
          exp_start = W * (start / W);
        end
        chk(ph_ok, framed ? "R3" : "R2", 32'(start), 32'(exp_start));
        exp_sync = framed && (start == m + 1 + 2 * W);
        chk(sync_out == exp_sync, (framed && start > m + 1 + 2 * W) ? "R6" : "R5",
            32'(sync_out), 32'(exp_sync));
        chk((^{word_out, sync_out, parity_out}) == !even_par_sel, "R7",
            32'(parity_out), 32'(even_par_sel));
        if (framed && sync_out) frame_hold = 1'b1;
      end
      if (it < nbits) begin
        ser_in = bits[pos];
        pos++;
      end else ser_in = 1'b0;
      even_par_sel = ((pos * 7) % 5) > 1;
      rst_req = (srst >= 0 && pos > srst && pos <= srst + 15);
    end
    exp_n = framed ? ((m + 1) / W + (nbits - m - 1) / W) : nbits / W;
    chk(words == exp_n, framed ? "R4" : "R6", 32'(words), 32'(exp_n));
    chk(syncs == (framed ? 1 : 0), framed ? "R5" : "R6", 32'(syncs), framed ? 32'd1 : 32'd0);
  endtask

  initial begin
    // Sweep the marker across every word phase; prefix 24 lands it on a word end.
    for (int l = 0; l < W; l++) begin
      do_reset(1'b0);
      push_prefix(l);
      push_frame();
      push_payload(32);
      run_stream(1'b1, l + 48 * 8 + 8 - 1, -1);
    end
    // Second frame at another phase must be ignored once hold is raised.
    do_reset(1'b0);
    push_prefix(5);
    push_frame();
    push_payload(32);
    push_prefix(13);
    push_frame();
    push_payload(16);
    run_stream(1'b1, 5 + 48 * 8 + 8 - 1, -1);
    // Plain demux after reset, with a frame in the data and a short reset pulse.
    do_reset(1'b1);
    push_payload(8);
    push_prefix(9);
    push_frame();
    push_payload(40);
    run_stream(1'b0, 0, 200);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule